// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block runs the transmit and receive descriptor rings of a packet MAC. Both rings sit in one descriptor table held inside the block. Each descriptor is a status/control word followed by a buffer-address word. A host fills the table over a simple 32-bit register bus and sets a count that divides it. The entries below the count form the transmit ring. The entries from the count up to the end of the table form the receive ring.

On the transmit side the sequencer watches the current descriptor. When the host hands it over, the sequencer offers the buffer address, length and per-frame options to a frame engine through a request/done handshake. On completion it writes the engine's status into the same word and returns ownership to the host.

On the receive side it offers the current empty descriptor to the engine. When the engine reports a finished frame, the sequencer records the length and error flags and advances. If no empty descriptor is available, it drops the frame and raises a busy request. Interrupt requests are one-cycle pulses for frame completion and for errors.

Top module: `bdRingSeq`

## Requirements
- R1: After reset every table word reads 0, the count register reads NUM_BD/2 (64), txReq and rxAvail are low and no interrupt pulse occurs.
- R2: The count register is at byte address 0x020. Descriptor i has its status word at 0x400+8*i and its buffer address at 0x404+8*i. Read data appears on hostRdData in the cycle after hostRdEn.
- R3: A count write stores min(value, NUM_BD). It moves the transmit pointer to entry 0 and the receive pointer to entry count.
- R4: When the current transmit descriptor has bit 15 (ready) set, txReq rises with no further action from the host. txReq then carries the buffer address, the length (status bits 31:16), txCrcEn (bit 11) and txPadEn (bit 12). It stays high until txDone. It does not rise while bit 15 is clear.
- R5: On txDone, the descriptor's bit 15 is cleared and bits 8:0 are replaced by txStatus. All other bits are unchanged.
- R6: After a transmit completion, the pointer goes to entry 0 if the descriptor's bit 13 (wrap) is set or if it was the last transmit entry (count-1). Otherwise it goes to the next entry.
- R7: One cycle after txDone, txFrameIrq pulses if the descriptor's bit 14 was set. txErrIrq pulses if txStatus is non-zero.
- R8: rxAvail is high, with rxBufAddr from the current receive descriptor, exactly when that descriptor has bit 15 (empty) set. rxAvail is always low when count equals NUM_BD.
- R9: On rxDone with an empty current descriptor, bits 31:16 become rxLen, bit 15 is cleared, bits 8:0 become rxStatus and bits 14:9 are kept. The pointer then goes to entry count if bit 13 was set or the entry was NUM_BD-1, and to the next entry otherwise.
- R10: One cycle after an accepted rxDone, rxFrameIrq pulses if bit 14 was set. rxErrIrq pulses if rxStatus bits 7:0 are non-zero; bit 8 (control frame) alone is not an error.
- R11: rxDone while the current receive descriptor is not empty leaves the table and the pointer unchanged. It pulses rxBusyIrq and no frame interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | 11 | Host byte address |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Registered host read data |
| txReq | output | 1 | Transmit frame request to engine |
| txBufAddr | output | 32 | Transmit buffer address |
| txLen | output | 16 | Transmit frame length |
| txCrcEn | output | 1 | Append CRC for this frame |
| txPadEn | output | 1 | Pad this frame if short |
| txDone | input | 1 | Engine finished the requested frame |
| txStatus | input | 9 | Transmit completion status bits 8:0 |
| rxAvail | output | 1 | An empty receive descriptor is offered |
| rxBufAddr | output | 32 | Receive buffer address |
| rxDone | input | 1 | Engine finished receiving a frame |
| rxLen | input | 16 | Received frame length |
| rxStatus | input | 9 | Receive status bits 8:0 |
| txFrameIrq | output | 1 | Transmit frame interrupt pulse |
| txErrIrq | output | 1 | Transmit error interrupt pulse |
| rxFrameIrq | output | 1 | Receive frame interrupt pulse |
| rxErrIrq | output | 1 | Receive error interrupt pulse |
| rxBusyIrq | output | 1 | Receive frame dropped pulse |

## Verification
Transmit descriptors are completed with a clean status and with a mixed error status. This separates field replacement in bits 8:0 from preservation of the option bits, and it separates the frame pulse from the error pulse.

Wrap handling is tested three ways. A descriptor with the wrap bit is followed by a ready descriptor that must be skipped. The last transmit entry is completed while an empty receive descriptor sits right after it. A receive ring is set up at the top of the table.

Receive frames are given a control-frame-only status and a real error status, and one frame arrives while no descriptor is empty. This shows that bit 8 is not an error, and that a dropped frame leaves the table and the pointer untouched.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int OWN_BIT  = 15;
  localparam int IRQ_BIT  = 14;
  localparam int WRAP_BIT = 13;
  localparam int PAD_BIT  = 12;
  localparam int CRC_BIT  = 11;
  localparam int STAT_W   = 9;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;
    logic txWb;
    logic rxWb;
  } bdStrobe_t;
endpackage

// File: rtl/bdr_datapath.sv
module bdr_datapath
  import bdr_pkg::*;
#(
  parameter int NUM_BD     = 128,
  parameter int ADDR_W     = 11,
  parameter int CNT_OFFSET = 'h020,
  parameter int TBL_BASE   = 'h400
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWrEn,
  input  logic                       hostRdEn,
  input  logic [ADDR_W-1:0]          hostAddr,
  input  logic [31:0]                hostWrData,
  output logic [31:0]                hostRdData,
  input  bdStrobe_t                  strb,
  input  logic [$clog2(NUM_BD)-1:0]  txIdx,
  input  logic [$clog2(NUM_BD)-1:0]  rxIdx,
  input  logic [STAT_W-1:0]          txStatus,
  input  logic [15:0]                rxLen,
  input  logic [STAT_W-1:0]          rxStatus,
  output logic                       txOwn,
  output logic                       txIrqEn,
  output logic                       txWrap,
  output logic                       rxOwn,
  output logic                       rxIrqEn,
  output logic                       rxWrap,
  output logic [31:0]                rxBufAddr,
  output logic [31:0]                txBufAddr,
  output logic [15:0]                txLen,
  output logic                       txCrcEn,
  output logic                       txPadEn,
  output logic [$clog2(NUM_BD+1)-1:0] txCount,
  output logic                       cntWrite,
  output logic [$clog2(NUM_BD+1)-1:0] cntNew
);
  localparam int WORDS  = 2 * NUM_BD;
  localparam int IDX_W  = $clog2(NUM_BD);
  localparam int WIDX_W = IDX_W + 1;
  localparam int CNT_W  = $clog2(NUM_BD + 1);
  localparam int TAG_W  = ADDR_W - WIDX_W - 2;
  localparam logic [TAG_W-1:0] TBL_TAG = TAG_W'(TBL_BASE >> (WIDX_W + 2));

  logic [31:0] descMem [WORDS];
  logic [WIDX_W-1:0] hostWord;
  logic hostInTbl, hostIsCnt;
  logic [31:0] txStatWord, rxStatWord, txWbWord, rxWbWord;

  assign hostWord  = hostAddr[WIDX_W+1:2];
  assign hostInTbl = hostAddr[ADDR_W-1:WIDX_W+2] == TBL_TAG;
  assign hostIsCnt = hostAddr == ADDR_W'(CNT_OFFSET);
  assign cntWrite  = hostWrEn && hostIsCnt;
  assign cntNew    = (hostWrData > 32'(NUM_BD)) ? CNT_W'(NUM_BD) : hostWrData[CNT_W-1:0];

  assign txStatWord = descMem[{txIdx, 1'b0}];
  assign rxStatWord = descMem[{rxIdx, 1'b0}];
  assign rxBufAddr  = descMem[{rxIdx, 1'b1}];
  assign txOwn   = txStatWord[OWN_BIT];
  assign txIrqEn = txStatWord[IRQ_BIT];
  assign txWrap  = txStatWord[WRAP_BIT];
  assign rxOwn   = rxStatWord[OWN_BIT];
  assign rxIrqEn = rxStatWord[IRQ_BIT];
  assign rxWrap  = rxStatWord[WRAP_BIT];

  // completion words: ownership returned, status field replaced
  assign txWbWord = {txStatWord[31:16], 1'b0, txStatWord[14:STAT_W], txStatus};
  assign rxWbWord = {rxLen, 1'b0, rxStatWord[14:STAT_W], rxStatus};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) descMem[i] <= '0;
      txCount    <= CNT_W'(NUM_BD / 2);
      hostRdData <= '0;
      txBufAddr  <= '0;
      txLen      <= '0;
      txCrcEn    <= 1'b0;
      txPadEn    <= 1'b0;
    end else begin
      if (hostWrEn && hostInTbl) descMem[hostWord] <= hostWrData;
      // engine write-back takes priority over a host write to the same word
      if (strb.txWb) descMem[{txIdx, 1'b0}] <= txWbWord;
      if (strb.rxWb) descMem[{rxIdx, 1'b0}] <= rxWbWord;
      if (cntWrite) txCount <= cntNew;
      if (hostRdEn)
        hostRdData <= hostInTbl ? descMem[hostWord] : (hostIsCnt ? 32'(txCount) : '0);
      if (strb.txLoad) begin
        txBufAddr <= descMem[{txIdx, 1'b1}];
        txLen     <= txStatWord[31:16];
        txCrcEn   <= txStatWord[CRC_BIT];
        txPadEn   <= txStatWord[PAD_BIT];
      end
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNT_W'(NUM_BD));
  a_r5_ready_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.txWb |=> !descMem[$past({txIdx, 1'b0})][OWN_BIT]);
  a_r9_empty_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxWb |=> !descMem[$past({rxIdx, 1'b0})][OWN_BIT]);
endmodule

// File: rtl/bdr_control.sv
module bdr_control
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        txOwn,
  input  logic                        txIrqEn,
  input  logic                        txWrap,
  input  logic                        rxOwn,
  input  logic                        rxIrqEn,
  input  logic                        rxWrap,
  input  logic [$clog2(NUM_BD+1)-1:0] txCount,
  input  logic                        cntWrite,
  input  logic [$clog2(NUM_BD+1)-1:0] cntNew,
  input  logic                        txDone,
  input  logic [STAT_W-1:0]           txStatus,
  input  logic                        rxDone,
  input  logic [7:0]                  rxErrBits,
  output bdStrobe_t                   strb,
  output logic [$clog2(NUM_BD)-1:0]   txIdx,
  output logic [$clog2(NUM_BD)-1:0]   rxIdx,
  output logic                        txReq,
  output logic                        rxAvail,
  output logic                        txFrameIrq,
  output logic                        txErrIrq,
  output logic                        rxFrameIrq,
  output logic                        rxErrIrq,
  output logic                        rxBusyIrq
);
  localparam int IDX_W = $clog2(NUM_BD);
  localparam int CNT_W = $clog2(NUM_BD + 1);

  logic txBusy, rxValid, txOn, rxAccept, txLast, rxLast;
  logic [IDX_W-1:0] txPtr, rxPtr, txNext, rxNext;

  assign rxValid  = txCount < CNT_W'(NUM_BD);
  assign txOn     = txCount != '0;
  assign rxAvail  = rxValid && rxOwn;
  assign rxAccept = rxDone && rxAvail;
  assign txReq    = txBusy;
  assign txIdx    = txPtr;
  assign rxIdx    = rxPtr;

  // idle transmit side polls the current descriptor every cycle
  assign strb.txLoad = !txBusy && txOn && txOwn;
  assign strb.txWb   = txBusy && txDone;
  assign strb.rxWb   = rxAccept;

  assign txLast = (CNT_W'(txPtr) + CNT_W'(1)) >= txCount;
  assign rxLast = rxPtr == IDX_W'(NUM_BD - 1);
  assign txNext = (txWrap || txLast) ? '0 : txPtr + IDX_W'(1);
  assign rxNext = (rxWrap || rxLast) ? IDX_W'(txCount) : rxPtr + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy     <= 1'b0;
      txPtr      <= '0;
      rxPtr      <= IDX_W'(NUM_BD / 2);
      txFrameIrq <= 1'b0;
      txErrIrq   <= 1'b0;
      rxFrameIrq <= 1'b0;
      rxErrIrq   <= 1'b0;
      rxBusyIrq  <= 1'b0;
    end else begin
      if (strb.txLoad)    txBusy <= 1'b1;
      else if (strb.txWb) txBusy <= 1'b0;

      if (cntWrite) begin
        txPtr <= '0;
        rxPtr <= IDX_W'(cntNew);
      end else begin
        if (strb.txWb) txPtr <= txNext;
        if (rxAccept)  rxPtr <= rxNext;
      end

      txFrameIrq <= strb.txWb && txIrqEn;
      txErrIrq   <= strb.txWb && (txStatus != '0);
      rxFrameIrq <= rxAccept && rxIrqEn;
      rxErrIrq   <= rxAccept && (rxErrBits != '0);
      rxBusyIrq  <= rxDone && !rxAvail;
    end
  end

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !txDone) |=> txReq);
  a_r6_tx_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txWb && txWrap && !cntWrite) |=> (txIdx == '0));
  a_r7_err_after_done: assert property (@(posedge clk) disable iff (!rstN)
    txErrIrq |-> $past(txReq && txDone));
  a_r8_rx_in_region: assert property (@(posedge clk) disable iff (!rstN)
    rxAvail |-> (CNT_W'(rxIdx) >= txCount));
  a_r11_busy_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rxBusyIrq && rxFrameIrq));
endmodule

// File: rtl/bdRingSeq.sv
module bdRingSeq
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic              txReq,
  output logic [31:0]       txBufAddr,
  output logic [15:0]       txLen,
  output logic              txCrcEn,
  output logic              txPadEn,
  input  logic              txDone,
  input  logic [8:0]        txStatus,
  output logic              rxAvail,
  output logic [31:0]       rxBufAddr,
  input  logic              rxDone,
  input  logic [15:0]       rxLen,
  input  logic [8:0]        rxStatus,
  output logic              txFrameIrq,
  output logic              txErrIrq,
  output logic              rxFrameIrq,
  output logic              rxErrIrq,
  output logic              rxBusyIrq
);
  localparam int IDX_W = $clog2(NUM_BD);
  localparam int CNT_W = $clog2(NUM_BD + 1);

  bdStrobe_t strb;
  logic [IDX_W-1:0] txIdx, rxIdx;
  logic [CNT_W-1:0] txCount, cntNew;
  logic cntWrite, txOwn, txIrqEn, txWrap, rxOwn, rxIrqEn, rxWrap;

  bdr_datapath #(.NUM_BD(NUM_BD), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .strb(strb), .txIdx(txIdx), .rxIdx(rxIdx),
    .txStatus(txStatus), .rxLen(rxLen), .rxStatus(rxStatus),
    .txOwn(txOwn), .txIrqEn(txIrqEn), .txWrap(txWrap),
    .rxOwn(rxOwn), .rxIrqEn(rxIrqEn), .rxWrap(rxWrap),
    .rxBufAddr(rxBufAddr), .txBufAddr(txBufAddr), .txLen(txLen),
    .txCrcEn(txCrcEn), .txPadEn(txPadEn),
    .txCount(txCount), .cntWrite(cntWrite), .cntNew(cntNew)
  );

  bdr_control #(.NUM_BD(NUM_BD)) u_ctl (
    .clk(clk), .rstN(rstN),
    .txOwn(txOwn), .txIrqEn(txIrqEn), .txWrap(txWrap),
    .rxOwn(rxOwn), .rxIrqEn(rxIrqEn), .rxWrap(rxWrap),
    .txCount(txCount), .cntWrite(cntWrite), .cntNew(cntNew),
    .txDone(txDone), .txStatus(txStatus),
    .rxDone(rxDone), .rxErrBits(rxStatus[7:0]),
    .strb(strb), .txIdx(txIdx), .rxIdx(rxIdx),
    .txReq(txReq), .rxAvail(rxAvail),
    .txFrameIrq(txFrameIrq), .txErrIrq(txErrIrq),
    .rxFrameIrq(rxFrameIrq), .rxErrIrq(rxErrIrq), .rxBusyIrq(rxBusyIrq)
  );
endmodule

// File: tb/bdRingSeq_tb.sv
module bdRingSeq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [10:0] hostAddr = '0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic txReq, txCrcEn, txPadEn, rxAvail;
  logic [31:0] txBufAddr, rxBufAddr;
  logic [15:0] txLen;
  logic txDone = 1'b0, rxDone = 1'b0;
  logic [8:0] txStatus = '0, rxStatus = '0;
  logic [15:0] rxLen = '0;
  logic txFrameIrq, txErrIrq, rxFrameIrq, rxErrIrq, rxBusyIrq;

  int nVec = 0, nBad = 0;
  int cTxF = 0, cTxE = 0, cRxF = 0, cRxE = 0, cBusy = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bdRingSeq u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .txReq(txReq), .txBufAddr(txBufAddr), .txLen(txLen),
    .txCrcEn(txCrcEn), .txPadEn(txPadEn), .txDone(txDone), .txStatus(txStatus),
    .rxAvail(rxAvail), .rxBufAddr(rxBufAddr), .rxDone(rxDone), .rxLen(rxLen),
    .rxStatus(rxStatus), .txFrameIrq(txFrameIrq), .txErrIrq(txErrIrq),
    .rxFrameIrq(rxFrameIrq), .rxErrIrq(rxErrIrq), .rxBusyIrq(rxBusyIrq)
  );

  always @(negedge clk) begin
    if (txFrameIrq) cTxF++;
    if (txErrIrq)   cTxE++;
    if (rxFrameIrq) cRxF++;
    if (rxErrIrq)   cRxE++;
    if (rxBusyIrq)  cBusy++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWr(logic [10:0] a, logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic hostRd(logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRdEn = 1'b0;
    d = hostRdData;
  endtask

  function automatic logic [10:0] stA(int i); return 11'('h400 + 8 * i); endfunction
  function automatic logic [10:0] bufA(int i); return 11'('h404 + 8 * i); endfunction

  task automatic waitReq();
    for (int i = 0; i < 20; i++) begin
      if (txReq) break;
      @(negedge clk);
    end
  endtask

  task automatic finishTx(logic [8:0] st);
    txDone = 1'b1; txStatus = st;
    @(negedge clk);
    txDone = 1'b0; txStatus = '0;
    @(negedge clk);
  endtask

  task automatic pulseRx(logic [15:0] len, logic [8:0] st);
    @(negedge clk);
    rxDone = 1'b1; rxLen = len; rxStatus = st;
    @(negedge clk);
    rxDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic idleNoReq(string tag);
    for (int i = 0; i < 5; i++) @(negedge clk);
    chk(tag, 32'(txReq), 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 txReq", 32'(txReq), 0);
    chk("R1 rxAvail", 32'(rxAvail), 0);
    hostRd(11'h020, d); chk("R1 R2 count reset", d, 32'd64);
    hostRd(stA(5), d);  chk("R1 table zero", d, 0);
    chk("R1 no irq", 32'(cTxF + cTxE + cRxF + cRxE + cBusy), 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    hostWr(11'h020, 32'd200);
    hostRd(11'h020, d); chk("R3 clamp", d, 32'd128);
    chk("R8 no rx ring", 32'(rxAvail), 0);
    hostWr(11'h020, 32'd4);
    hostRd(11'h020, d); chk("R3 count 4", d, 32'd4);
  endtask

  task automatic t_txBasic();
    logic [31:0] d; int f0 = cTxF, e0 = cTxE;
    hostWr(bufA(0), 32'h0000_1000);
    hostWr(stA(0), 32'h003C_C800);
    waitReq();
    chk("R4 req", 32'(txReq), 1);
    chk("R4 addr", txBufAddr, 32'h1000);
    chk("R4 len", 32'(txLen), 32'd60);
    chk("R4 crc/pad", {30'd0, txCrcEn, txPadEn}, 32'd2);
    repeat (3) @(negedge clk);
    chk("R4 held", 32'(txReq), 1);
    finishTx(9'h000);
    chk("R4 released", 32'(txReq), 0);
    chk("R7 frame irq", 32'(cTxF - f0), 1);
    chk("R7 no err irq", 32'(cTxE - e0), 0);
    hostRd(stA(0), d); chk("R5 writeback clean", d, 32'h003C_4800);
  endtask

  task automatic t_txErr();
    logic [31:0] d; int f0 = cTxF, e0 = cTxE;
    hostWr(bufA(1), 32'h0000_1100);
    hostWr(stA(1), 32'h0064_9100);
    waitReq();
    chk("R4 addr1", txBufAddr, 32'h1100);
    chk("R4 len1", 32'(txLen), 32'd100);
    chk("R4 crc/pad1", {30'd0, txCrcEn, txPadEn}, 32'd1);
    finishTx(9'h013);
    chk("R7 no frame irq", 32'(cTxF - f0), 0);
    chk("R7 err irq", 32'(cTxE - e0), 1);
    hostRd(stA(1), d); chk("R5 writeback err", d, 32'h0064_1013);
  endtask

  task automatic t_txWrap();
    hostWr(bufA(3), 32'h0000_3000);
    hostWr(stA(3), 32'h0010_8000);
    hostWr(bufA(2), 32'h0000_2000);
    hostWr(stA(2), 32'h0020_A000);
    waitReq();
    chk("R6 entry2", txBufAddr, 32'h2000);
    finishTx(9'h000);
    idleNoReq("R6 wrap skips entry3");
    hostWr(stA(0), 32'h0040_8000);
    waitReq();
    chk("R6 back at entry0", txBufAddr, 32'h1000);
    finishTx(9'h000);
  endtask

  task automatic t_txEnd();
    hostWr(bufA(4), 32'hDEAD_0000);
    hostWr(stA(4), 32'h0010_8000);
    hostWr(stA(1), 32'h0010_8000);
    waitReq(); chk("R6 entry1", txBufAddr, 32'h1100); finishTx(9'h000);
    hostWr(stA(2), 32'h0020_8000);
    waitReq(); chk("R6 entry2 no wrap", txBufAddr, 32'h2000); finishTx(9'h000);
    waitReq(); chk("R6 entry3", txBufAddr, 32'h3000); finishTx(9'h000);
    idleNoReq("R6 last tx entry returns to 0");
    hostWr(stA(0), 32'h0040_8000);
    waitReq(); chk("R6 end wrap entry0", txBufAddr, 32'h1000); finishTx(9'h000);
  endtask

  task automatic t_rx();
    logic [31:0] d; int f0, e0, b0;
    hostWr(stA(4), 32'h0);
    chk("R8 not empty", 32'(rxAvail), 0);
    hostWr(bufA(4), 32'h0000_8000);
    hostWr(stA(4), 32'h0000_C0FF);
    chk("R8 avail", 32'(rxAvail), 1);
    chk("R8 addr", rxBufAddr, 32'h8000);
    f0 = cRxF; e0 = cRxE;
    pulseRx(16'h0040, 9'h100);
    chk("R10 frame irq", 32'(cRxF - f0), 1);
    chk("R10 control frame not error", 32'(cRxE - e0), 0);
    hostRd(stA(4), d); chk("R9 writeback", d, 32'h0040_4100);
    f0 = cRxF; b0 = cBusy;
    pulseRx(16'h0020, 9'h001);
    chk("R11 busy irq", 32'(cBusy - b0), 1);
    chk("R11 no frame irq", 32'(cRxF - f0), 0);
    hostRd(stA(5), d); chk("R11 table unchanged", d, 0);
    hostWr(bufA(5), 32'h0000_9000);
    hostWr(stA(5), 32'h0000_A000);
    chk("R11 pointer unchanged", rxBufAddr, 32'h9000);
    f0 = cRxF; e0 = cRxE;
    pulseRx(16'h05EE, 9'h006);
    chk("R10 no frame irq", 32'(cRxF - f0), 0);
    chk("R10 err irq", 32'(cRxE - e0), 1);
    hostRd(stA(5), d); chk("R9 writeback wrap", d, 32'h05EE_2006);
    chk("R9 wrapped to full entry4", 32'(rxAvail), 0);
    hostWr(stA(4), 32'h0000_8000);
    chk("R9 wrap to count", rxBufAddr, 32'h8000);
    chk("R9 avail again", 32'(rxAvail), 1);
  endtask

  task automatic t_rxEnd();
    logic [31:0] d;
    hostWr(11'h020, 32'd126);
    hostRd(11'h020, d); chk("R3 count 126", d, 32'd126);
    hostWr(bufA(126), 32'h0000_A000);
    hostWr(stA(126), 32'h0000_C000);
    hostWr(bufA(127), 32'h0000_B000);
    hostWr(stA(127), 32'h0000_8000);
    chk("R3 rx pointer at count", rxBufAddr, 32'hA000);
    pulseRx(16'd10, 9'h0);
    chk("R9 next entry", rxBufAddr, 32'hB000);
    pulseRx(16'd12, 9'h0);
    chk("R9 table end full", 32'(rxAvail), 0);
    hostWr(stA(126), 32'h0000_8000);
    chk("R9 table end wraps to count", rxBufAddr, 32'hA000);
    chk("R9 avail after end wrap", 32'(rxAvail), 1);
    chk("R4 no tx start without ready", 32'(txReq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_txBasic();
    t_txErr();
    t_txWrap();
    t_txEnd();
    t_rx();
    t_rxEnd();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule